// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block looks after one bank of general-purpose pins, 32 by default, behind a flat word-addressed register port. Writes take effect on the clock edge and reads are combinational. Software sets a drive value and a direction for each pin. It reads back each pin's level after the level has passed through a synchronizer. It can also arm each pin to report an event.

Five sense kinds are available for each pin: rising edge, falling edge, either edge, high level and low level. Three independent bit registers select the kind. A detected event sets a sticky status bit, and software clears that bit by writing a one to it. A per-pin enable mask gates each status bit, and the gated bits are ORed into one active-high interrupt line.

Pull resistor selection and drive-strength codes are stored as plain registers and are driven out unchanged to the pad ring. The drive-strength code is kept as bit planes: each of three registers holds one bit of every pin's 3-bit code.

Top module: `gpio_bank`

## Requirements
- R1: After reset every writable register is zero. As a result, padOut, padOe, pullUp, pullDown and driveCode are all zero, irq is low, and reads of the mask (0x18) and raw status (0x1C) return zero.
- R2: The register at 0x04 drives padOut. The register at 0x08 drives padOe, where 1 means the pin is an output and 0 means it is an input. Both registers read back the value last written.
- R3: A read of 0x00 returns padIn through a two-flop synchronizer. A change at padIn becomes readable after the second rising clock edge that follows the change, and not after the first.
- R4: The three sense registers set the event kind for each pin. The register at 0x0C selects the type (1 = level, 0 = edge). The register at 0x10 enables dual-edge sensing. The register at 0x14 selects polarity. With type 0 and dual 0, polarity 1 senses rising edges and polarity 0 senses falling edges. An edge event sets the pin's raw status bit (read at 0x1C) on the third rising edge after the pad changes. All three sense registers read back the value last written.
- R5: With type 0 and dual 1, both a rising and a falling edge set the status bit, and the polarity setting has no effect.
- R6: With type 1, the status bit is set on every cycle in which the synchronized level equals the polarity (1 = high, 0 = low). A clear write has no lasting effect while that level holds.
- R7: Bit n of the mask register (0x18) set to 1 enables pin n, and 0 blocks it. A read of 0x20 returns the raw status ANDed with the mask. irq is high exactly when that result is nonzero.
- R8: Writing a 1 to bit n at 0x24 clears raw status bit n, and writing a 0 leaves the bit unchanged. If a clear and a new event for the same pin arrive in the same cycle, the bit stays set.
- R9: The pull-select register (0x34, 1 = up, 0 = down) and the pull-enable register (0x38) read back. For each pin, pullUp = enable AND select and pullDown = enable AND NOT select.
- R10: The drive-strength planes sit at 0x58, 0x5C and 0x60 and hold bits 0, 1 and 2 of each pin's 3-bit code. driveCode[3n+2:3n] is the code of pin n, and each plane reads back.
- R11: Reads of offsets that are not mapped return zero. Writes to 0x00, 0x1C and 0x20 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 9 | Byte offset of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| padIn | input | 32 | Pin levels from the pads |
| padOut | output | 32 | Pin drive values |
| padOe | output | 32 | Pin output enables |
| pullUp | output | 32 | Pull-up enable for each pin |
| pullDown | output | 32 | Pull-down enable for each pin |
| driveCode | output | 96 | 3-bit drive-strength code for each pin |
| irq | output | 1 | Level-high interrupt request |

## Verification
The hardest case to produce is a clear write that lands on the same clock edge as a new edge event for the same pin. That edge is the third one after the pad changes, once the value has passed through the synchronizer and the previous-sample register. The stimulus changes the pad on a falling clock edge and issues the clear exactly two clock periods later, so that the write commits on the edge where the event is flagged. Randomly chosen pins, sense kinds and toggle decisions, taken from a fixed seed, then exercise all five sense kinds against the bench's own event function. Directed cases cover level re-setting, the read-only offsets and offsets that are not mapped.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DRV_PLANES = 3;
  localparam int unsigned PLANE_W    = $clog2(DRV_PLANES);

  localparam int unsigned OFS_DIN   = 'h00;
  localparam int unsigned OFS_DOUT  = 'h04;
  localparam int unsigned OFS_OE    = 'h08;
  localparam int unsigned OFS_TYPE  = 'h0C;
  localparam int unsigned OFS_DUAL  = 'h10;
  localparam int unsigned OFS_POL   = 'h14;
  localparam int unsigned OFS_MASK  = 'h18;
  localparam int unsigned OFS_RAW   = 'h1C;
  localparam int unsigned OFS_MSTAT = 'h20;
  localparam int unsigned OFS_CLR   = 'h24;
  localparam int unsigned OFS_PSEL  = 'h34;
  localparam int unsigned OFS_PEN   = 'h38;
  localparam int unsigned OFS_DRV   = 'h58;

  typedef struct packed {
    logic                  wrDout;
    logic                  wrOe;
    logic                  wrType;
    logic                  wrDual;
    logic                  wrPol;
    logic                  wrMask;
    logic                  wrClr;
    logic                  wrPullSel;
    logic                  wrPullEn;
    logic [DRV_PLANES-1:0] wrDrv;
  } gpioStrobe_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_DIN, RD_DOUT, RD_OE, RD_TYPE, RD_DUAL, RD_POL,
    RD_MASK, RD_RAW, RD_MSTAT, RD_PSEL, RD_PEN, RD_DRV
  } rdSel_t;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  output gpioStrobe_t        strobe,
  output rdSel_t             rdSel,
  output logic [PLANE_W-1:0] rdPlane
);
  always_comb begin
    strobe  = '0;
    rdSel   = RD_NONE;
    rdPlane = '0;
    if (regAddr == ADDR_W'(OFS_DIN)) begin
      rdSel = RD_DIN;
    end else if (regAddr == ADDR_W'(OFS_DOUT)) begin
      rdSel = RD_DOUT;
      strobe.wrDout = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_OE)) begin
      rdSel = RD_OE;
      strobe.wrOe = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_TYPE)) begin
      rdSel = RD_TYPE;
      strobe.wrType = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_DUAL)) begin
      rdSel = RD_DUAL;
      strobe.wrDual = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_POL)) begin
      rdSel = RD_POL;
      strobe.wrPol = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_MASK)) begin
      rdSel = RD_MASK;
      strobe.wrMask = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_RAW)) begin
      rdSel = RD_RAW;
    end else if (regAddr == ADDR_W'(OFS_MSTAT)) begin
      rdSel = RD_MSTAT;
    end else if (regAddr == ADDR_W'(OFS_CLR)) begin
      strobe.wrClr = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_PSEL)) begin
      rdSel = RD_PSEL;
      strobe.wrPullSel = regWrEn;
    end else if (regAddr == ADDR_W'(OFS_PEN)) begin
      rdSel = RD_PEN;
      strobe.wrPullEn = regWrEn;
    end else begin
      for (int k = 0; k < DRV_PLANES; k++) begin
        if (regAddr == ADDR_W'(OFS_DRV + 4 * k)) begin
          rdSel          = RD_DRV;
          rdPlane        = PLANE_W'(k);
          strobe.wrDrv[k] = regWrEn;
        end
      end
    end
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_COUNT   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  gpioStrobe_t                     strobe,
  input  rdSel_t                          rdSel,
  input  logic [PLANE_W-1:0]              rdPlane,
  input  logic [PIN_COUNT-1:0]            wrData,
  input  logic [PIN_COUNT-1:0]            padIn,
  output logic [PIN_COUNT-1:0]            rdData,
  output logic [PIN_COUNT-1:0]            padOut,
  output logic [PIN_COUNT-1:0]            padOe,
  output logic [PIN_COUNT-1:0]            pullUp,
  output logic [PIN_COUNT-1:0]            pullDown,
  output logic [PIN_COUNT*DRV_PLANES-1:0] driveCode,
  output logic                            irq
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][PIN_COUNT-1:0] syncQ;
  logic [PIN_COUNT-1:0] prevQ, curS;
  logic [PIN_COUNT-1:0] doutQ, oeQ, typeQ, dualQ, polQ, maskQ;
  logic [PIN_COUNT-1:0] rawStat, pselQ, penQ;
  logic [DRV_PLANES-1:0][PIN_COUNT-1:0] drvPlane;
  logic [PIN_COUNT-1:0] riseV, fallV, edgeHit, levelHit, evt, clrMask, maskedStat;

  // input synchronizer and previous-sample register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end
  assign curS = syncQ[LAST];

  // event sense
  assign riseV    = curS & ~prevQ;
  assign fallV    = ~curS & prevQ;
  assign edgeHit  = (dualQ & (riseV | fallV)) | (~dualQ & polQ & riseV) | (~dualQ & ~polQ & fallV);
  assign levelHit = ~(curS ^ polQ);
  assign evt      = (typeQ & levelHit) | (~typeQ & edgeHit);
  assign clrMask  = strobe.wrClr ? wrData : '0;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doutQ    <= '0;
      oeQ      <= '0;
      typeQ    <= '0;
      dualQ    <= '0;
      polQ     <= '0;
      maskQ    <= '0;
      pselQ    <= '0;
      penQ     <= '0;
      drvPlane <= '0;
      rawStat  <= '0;
    end else begin
      if (strobe.wrDout)    doutQ <= wrData;
      if (strobe.wrOe)      oeQ   <= wrData;
      if (strobe.wrType)    typeQ <= wrData;
      if (strobe.wrDual)    dualQ <= wrData;
      if (strobe.wrPol)     polQ  <= wrData;
      if (strobe.wrMask)    maskQ <= wrData;
      if (strobe.wrPullSel) pselQ <= wrData;
      if (strobe.wrPullEn)  penQ  <= wrData;
      for (int k = 0; k < DRV_PLANES; k++) begin
        if (strobe.wrDrv[k]) drvPlane[k] <= wrData;
      end
      rawStat <= (rawStat & ~clrMask) | evt;
    end
  end

  assign maskedStat = rawStat & maskQ;
  assign irq        = |maskedStat;
  assign padOut     = doutQ;
  assign padOe      = oeQ;
  assign pullUp     = penQ & pselQ;
  assign pullDown   = penQ & ~pselQ;

  // bit-plane to per-pin code mapping
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    for (genvar k = 0; k < DRV_PLANES; k++) begin : g_plane
      assign driveCode[p*DRV_PLANES+k] = drvPlane[k][p];
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_DIN:   rdData = curS;
      RD_DOUT:  rdData = doutQ;
      RD_OE:    rdData = oeQ;
      RD_TYPE:  rdData = typeQ;
      RD_DUAL:  rdData = dualQ;
      RD_POL:   rdData = polQ;
      RD_MASK:  rdData = maskQ;
      RD_RAW:   rdData = rawStat;
      RD_MSTAT: rdData = maskedStat;
      RD_PSEL:  rdData = pselQ;
      RD_PEN:   rdData = penQ;
      RD_DRV: begin
        for (int k = 0; k < DRV_PLANES; k++) begin
          if (rdPlane == PLANE_W'(k)) rdData = drvPlane[k];
        end
      end
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_COUNT   = 32,
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            regWrEn,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [PIN_COUNT-1:0]            regWrData,
  output logic [PIN_COUNT-1:0]            regRdData,
  input  logic [PIN_COUNT-1:0]            padIn,
  output logic [PIN_COUNT-1:0]            padOut,
  output logic [PIN_COUNT-1:0]            padOe,
  output logic [PIN_COUNT-1:0]            pullUp,
  output logic [PIN_COUNT-1:0]            pullDown,
  output logic [PIN_COUNT*DRV_PLANES-1:0] driveCode,
  output logic                            irq
);
  gpioStrobe_t        strobe;
  rdSel_t             rdSel;
  logic [PLANE_W-1:0] rdPlane;

  gpio_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .rdPlane (rdPlane)
  );

  gpio_bank_dp #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .rdPlane   (rdPlane),
    .wrData    (regWrData),
    .padIn     (padIn),
    .rdData    (regRdData),
    .padOut    (padOut),
    .padOe     (padOe),
    .pullUp    (pullUp),
    .pullDown  (pullDown),
    .driveCode (driveCode),
    .irq       (irq)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 32,
  parameter int unsigned ADDR_W    = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [PIN_COUNT-1:0] regWrData,
  input logic [PIN_COUNT-1:0] regRdData,
  input logic [PIN_COUNT-1:0] padOe,
  input logic                 irq,
  input logic [PIN_COUNT-1:0] rawStat,
  input logic [PIN_COUNT-1:0] maskQ,
  input logic [PIN_COUNT-1:0] evt
);
  function automatic logic isMapped(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = (a == ADDR_W'(OFS_DIN))  || (a == ADDR_W'(OFS_DOUT)) || (a == ADDR_W'(OFS_OE))   ||
          (a == ADDR_W'(OFS_TYPE)) || (a == ADDR_W'(OFS_DUAL)) || (a == ADDR_W'(OFS_POL))  ||
          (a == ADDR_W'(OFS_MASK)) || (a == ADDR_W'(OFS_RAW))  || (a == ADDR_W'(OFS_MSTAT)) ||
          (a == ADDR_W'(OFS_PSEL)) || (a == ADDR_W'(OFS_PEN));
    for (int k = 0; k < DRV_PLANES; k++) hit = hit || (a == ADDR_W'(OFS_DRV + 4 * k));
    return hit;
  endfunction

  logic clrWr;
  assign clrWr = regWrEn && (regAddr == ADDR_W'(OFS_CLR));

  // R2: output enable follows the written value
  a_r2_oe_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFS_OE)) |=> (padOe == $past(regWrData)));

  // R7: no interrupt while every pin is masked off
  a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (maskQ != '0));

  // R8: without a clear write, no status bit falls
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> ((rawStat & $past(rawStat)) == $past(rawStat)));

  // R8: clearing all bits with no new event empties the status
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && regWrData == '1 && evt == '0) |=> (rawStat == '0));

  // R11: write to raw status with no event leaves it unchanged
  a_r11_status_ro: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(OFS_RAW) && evt == '0) |=> (rawStat == $past(rawStat)));

  // R11: offsets that are not mapped read zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped(regAddr) |-> (regRdData == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .padOe     (padOe),
  .irq       (irq),
  .rawStat   (u_dp.rawStat),
  .maskQ     (u_dp.maskQ),
  .evt       (u_dp.evt)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  localparam logic [8:0] A_DIN = 9'h00, A_DOUT = 9'h04, A_OE = 9'h08, A_TYPE = 9'h0C,
                         A_DUAL = 9'h10, A_POL = 9'h14, A_MASK = 9'h18, A_RAW = 9'h1C,
                         A_MSTAT = 9'h20, A_CLR = 9'h24, A_PSEL = 9'h34, A_PEN = 9'h38,
                         A_DRV0 = 9'h58, A_DRV1 = 9'h5C, A_DRV2 = 9'h60;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe, pullUp, pullDown;
  logic [95:0] driveCode;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .pullUp(pullUp), .pullDown(pullDown),
    .driveCode(driveCode), .irq(irq)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [95:0] codeOf(input logic [31:0] p0, input logic [31:0] p1,
                                          input logic [31:0] p2);
    logic [95:0] c;
    for (int p = 0; p < 32; p++) begin
      c[p*3]   = p0[p];
      c[p*3+1] = p1[p];
      c[p*3+2] = p2[p];
    end
    return c;
  endfunction

  // mode: 0 rise, 1 fall, 2 both, 3 high, 4 low
  function automatic logic senseHit(input int mode, input logic o, input logic n);
    case (mode)
      0: return !o && n;
      1: return o && !n;
      2: return o ^ n;
      3: return n;
      default: return !n;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, mDout, mOe, mPsel, mPen, mD0, mD1, mD2, base, nextIn, mask;
    void'($urandom(32'h5EED_6A7B));
    tick(4);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 padOut", padOut, 0);
    chk("R1 padOe", padOe, 0);
    chk("R1 pulls", {pullUp, pullDown}, 0);
    chk("R1 driveCode", driveCode, 0);
    chk("R1 irq", irq, 0);
    rd(A_MASK, d); chk("R1 mask", d, 0);
    rd(A_RAW, d);  chk("R1 raw", d, 0);

    // R2 drive value and direction
    wr(A_DOUT, 32'hA5A5_0F0F); wr(A_OE, 32'hFFFF_0000);
    chk("R2 padOut", padOut, 32'hA5A5_0F0F);
    chk("R2 padOe", padOe, 32'hFFFF_0000);
    rd(A_DOUT, d); chk("R2 dout readback", d, 32'hA5A5_0F0F);
    rd(A_OE, d);   chk("R2 oe readback", d, 32'hFFFF_0000);

    // R3 two-flop synchronizer latency
    padIn = 32'h1234_5678;
    tick(1); rd(A_DIN, d); chk("R3 din after one edge", d, 0);
    tick(1); rd(A_DIN, d); chk("R3 din after two edges", d, 32'h1234_5678);
    padIn = 0; tick(4); wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_RAW, d); chk("R8 clear all", d, 0);

    // R4 sense register readback
    wr(A_TYPE, 32'h0000_00F0); wr(A_DUAL, 32'h0000_0F00); wr(A_POL, 32'h0000_F000);
    wr(A_MASK, 32'h8000_0001);
    rd(A_TYPE, d); chk("R4 type readback", d, 32'h0000_00F0);
    rd(A_DUAL, d); chk("R4 dual readback", d, 32'h0000_0F00);
    rd(A_POL, d);  chk("R4 pol readback", d, 32'h0000_F000);
    rd(A_MASK, d); chk("R7 mask readback", d, 32'h8000_0001);

    // R8 clear colliding with a rising-edge event on pin 3
    wr(A_TYPE, 0); wr(A_DUAL, 0); wr(A_POL, 32'hFFFF_FFFF); wr(A_MASK, 32'h0000_0008);
    tick(4); wr(A_CLR, 32'hFFFF_FFFF);
    padIn = 32'h0000_0008;
    tick(2); wr(A_CLR, 32'h0000_0008);
    rd(A_RAW, d); chk("R8 clear and event same cycle", d, 32'h0000_0008);
    chk("R7 irq with enabled bit", irq, 1);
    wr(A_CLR, 32'h0000_0000);
    rd(A_RAW, d); chk("R8 write zero no effect", d, 32'h0000_0008);
    wr(A_CLR, 32'h0000_0008);
    rd(A_RAW, d); chk("R8 clear one", d, 0);
    chk("R7 irq cleared", irq, 0);

    // R6 level high on pin 5 re-sets after clear
    padIn = 0; tick(4);
    wr(A_TYPE, 32'h0000_0020); wr(A_POL, 32'h0000_0020); wr(A_MASK, 32'h0000_0020);
    wr(A_CLR, 32'hFFFF_FFFF);
    padIn = 32'h0000_0020; tick(3);
    rd(A_RAW, d); chk("R6 level high sets", d, 32'h0000_0020);
    wr(A_CLR, 32'h0000_0020); tick(1);
    rd(A_RAW, d); chk("R6 level re-sets after clear", d, 32'h0000_0020);
    padIn = 0; tick(3); wr(A_CLR, 32'hFFFF_FFFF); tick(1);
    rd(A_RAW, d); chk("R6 level gone stays clear", d, 0);

    // R11 unmapped reads and read-only writes
    rd(9'h028, d); chk("R11 unmapped 0x28", d, 0);
    rd(9'h040, d); chk("R11 unmapped 0x40", d, 0);
    rd(9'h064, d); chk("R11 unmapped 0x64", d, 0);
    rd(9'h1FC, d); chk("R11 unmapped 0x1FC", d, 0);
    wr(A_RAW, 32'hFFFF_FFFF); wr(A_MSTAT, 32'hFFFF_FFFF); wr(A_DIN, 32'hFFFF_FFFF);
    rd(A_RAW, d); chk("R11 raw write ignored", d, 0);
    rd(A_DIN, d); chk("R11 din write ignored", d, 0);
    chk("R11 irq after ignored writes", irq, 0);

    // R10 directed drive planes
    wr(A_DRV0, 32'hFFFF_FFFF); wr(A_DRV1, 0); wr(A_DRV2, 32'h0000_0001);
    chk("R10 pin0 code 5", driveCode[2:0], 3'd5);
    chk("R10 pin31 code 1", driveCode[95:93], 3'd1);
    rd(A_DRV2, d); chk("R10 plane2 readback", d, 32'h0000_0001);

    // R2 R9 R10 random configuration
    mDout = padOut; mOe = padOe; mPsel = 0; mPen = 0;
    mD0 = 32'hFFFF_FFFF; mD1 = 0; mD2 = 32'h0000_0001;
    for (int i = 0; i < 40; i++) begin
      d = $urandom;
      case ($urandom_range(0, 6))
        0: begin wr(A_DOUT, d); mDout = d; end
        1: begin wr(A_OE, d);   mOe = d; end
        2: begin wr(A_PSEL, d); mPsel = d; end
        3: begin wr(A_PEN, d);  mPen = d; end
        4: begin wr(A_DRV0, d); mD0 = d; end
        5: begin wr(A_DRV1, d); mD1 = d; end
        default: begin wr(A_DRV2, d); mD2 = d; end
      endcase
      chk("R2 random padOut", padOut, mDout);
      chk("R2 random padOe", padOe, mOe);
      chk("R9 random pullUp", pullUp, mPen & mPsel);
      chk("R9 random pullDown", pullDown, mPen & ~mPsel);
      chk("R10 random driveCode", driveCode, codeOf(mD0, mD1, mD2));
    end
    rd(A_PSEL, d); chk("R9 pull select readback", d, mPsel);
    rd(A_PEN, d);  chk("R9 pull enable readback", d, mPen);

    // R4 R5 R6 R7 random sense trials
    for (int i = 0; i < 30; i++) begin
      int mode, p;
      bit toggle;
      logic hit;
      mode = $urandom_range(0, 4);
      p = $urandom_range(0, 31);
      toggle = $urandom_range(0, 1);
      mask = $urandom | (32'h1 << p) & {32{$urandom_range(0, 1) == 1}};
      wr(A_TYPE, (mode >= 3) ? 32'hFFFF_FFFF : 0);
      wr(A_DUAL, (mode == 2) ? 32'hFFFF_FFFF : 0);
      wr(A_POL, (mode == 0 || mode == 3) ? 32'hFFFF_FFFF : 0);
      wr(A_MASK, mask);
      case (mode)
        0, 3: base = 0;
        1, 4: base = 32'hFFFF_FFFF;
        default: base = $urandom;
      endcase
      padIn = base;
      tick(4);
      wr(A_CLR, 32'hFFFF_FFFF);
      nextIn = toggle ? (base ^ (32'h1 << p)) : base;
      padIn = nextIn;
      tick(3);
      hit = senseHit(mode, base[p], nextIn[p]);
      rd(A_RAW, d);
      chk(mode == 2 ? "R5 dual edge raw" : (mode >= 3 ? "R6 level raw" : "R4 edge raw"),
          d, hit ? (32'h1 << p) : 0);
      rd(A_MSTAT, d);
      chk("R7 masked status", d, hit ? ((32'h1 << p) & mask) : 0);
      chk("R7 irq", irq, hit && mask[p]);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule